// File: doc/BRIEF.md
# Reset Sequencer with Clock Qualification

This block orders the recovery of a chip after a power-on or low-voltage event. When either event flag is raised, the block holds the chip in internal reset. It then watches a series of clock check windows. The first window that reports a good oscillator ends the qualification, and the oscillator becomes the clock source. If fifty windows end without a good result, the block falls back to the internal self-clock and sets a status bit that stays set.

After qualification comes a counted reset sequence with two phases. First the block pulls the bidirectional reset pin low through an open-drain style enable. Then it lets the pin float for a fixed wait. At the end of the wait it reads the pin. If something outside still holds the pin low, internal reset stays asserted until the pin reads high.

A fresh event in any phase restarts the whole process from qualification. The analog detectors, the oscillator and the actual clock switch sit outside the block. They connect through the flag inputs and the select output.

Top module: `rstseq_top`

## Requirements
- R1: While `arstN` is low and after it rises, `intReset`, `pinDriveEn`, `selfClkSel` and `selfClkMode` are all 0, and the block stays idle.
- R2: A cycle with `porEvt` or `lvdEvt` high makes `intReset` 1 from the next cycle on, with `pinDriveEn` 0 while windows are being checked.
- R3: During qualification, a cycle with `winTick`=1 and `oscValid`=1 starts the drive phase on the next cycle with `selfClkSel`=0 (oscillator).
- R4: During qualification, the 50th `winTick` with `oscValid`=0 starts the drive phase on the next cycle with `selfClkSel`=1 and `selfClkMode`=1. After 49 such ticks, `pinDriveEn` is still 0.
- R5: Cycles without `winTick` do not count as windows. `winTick` and `oscValid` have no effect while idle, so `intReset` stays 0.
- R6: `pinDriveEn` is 1 for exactly 128 consecutive cycles in each completed sequence.
- R7: After the drive phase, `intReset` stays 1 for 64 cycles and then drops if `pinIn` is 1. If `pinIn` is 0 at that point, `intReset` stays 1 until a cycle with `pinIn`=1 and drops on the next cycle.
- R8: Once set, `selfClkMode` stays 1 through `lvdEvt` restarts and later sequences. Only `porEvt` (or `arstN`) clears it.
- R9: An event in any phase restarts the sequence. On the next cycle `pinDriveEn` is 0, `intReset` is 1 and `selfClkSel` is 0, and the full window count, drive length and wait length apply again.
- R10: A low `pinIn` while idle does not assert `intReset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arstN | input | 1 | Asynchronous active-low reset of the block's flops |
| porEvt | input | 1 | Power-on event flag |
| lvdEvt | input | 1 | Low-voltage event flag |
| pinIn | input | 1 | Level read back from the reset pin (1 = high) |
| oscValid | input | 1 | Oscillator judged good in the window ending now |
| winTick | input | 1 | One-cycle strobe marking the end of a check window |
| intReset | output | 1 | Internal reset to the rest of the chip |
| pinDriveEn | output | 1 | Enable that pulls the reset pin low |
| selfClkSel | output | 1 | Clock source select (1 = self-clock, 0 = oscillator) |
| selfClkMode | output | 1 | Sticky status: the fallback to self-clock was taken |

## Verification
A window counter that is off by one moves the fallback to the 49th or 51st failed window. This shows on `pinDriveEn` one window early or late. A wrong phase counter changes the 128-cycle drive pulse or the 64-cycle wait, and the measured lengths show this at the end of the first sequence. A control state that does not restart on an event leaves `pinDriveEn` or `selfClkSel` high on the cycle after the event. A sticky bit that is cleared by the wrong event shows at the status port after the next low-voltage restart. Each of these faults therefore reaches a port within one sequence, and mostly within a cycle of the faulty transition.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUAL,
    ST_DRIVE,
    ST_WAIT,
    ST_HOLD
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic winClr;
    logic winInc;
    logic cycClr;
    logic cycInc;
  } dpCmd_t;

endpackage

// File: rtl/rstseq_dpath.sv
module rstseq_dpath #(
  parameter int NUM_WIN   = 50,
  parameter int DRIVE_CYC = 128,
  parameter int WAIT_CYC  = 64
) (
  input  logic                  clk,
  input  logic                  arstN,
  input  rstseq_pkg::dpCmd_t    dpCmd,
  output logic                  winLast,
  output logic                  driveLast,
  output logic                  waitLast
);
  localparam int MAX_CYC = (DRIVE_CYC > WAIT_CYC) ? DRIVE_CYC : WAIT_CYC;
  localparam int CYC_W   = $clog2(MAX_CYC) + 1;
  localparam int WIN_W   = $clog2(NUM_WIN + 1);

  logic [WIN_W-1:0] winCnt;
  logic [CYC_W-1:0] cycCnt;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                                        winCnt <= '0;
    else if (dpCmd.winClr)                             winCnt <= '0;
    else if (dpCmd.winInc && winCnt != WIN_W'(NUM_WIN)) winCnt <= winCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)            cycCnt <= '0;
    else if (dpCmd.cycClr) cycCnt <= '0;
    else if (dpCmd.cycInc) cycCnt <= cycCnt + 1'b1;
  end

  assign winLast   = (winCnt == WIN_W'(NUM_WIN - 1));
  assign driveLast = (cycCnt == CYC_W'(DRIVE_CYC - 1));
  assign waitLast  = (cycCnt == CYC_W'(WAIT_CYC - 1));

  // R4
  win_sat_chk: assert property (@(posedge clk) disable iff (!arstN)
    winCnt <= WIN_W'(NUM_WIN));

  // R9
  win_clear_chk: assert property (@(posedge clk) disable iff (!arstN)
    dpCmd.winClr |=> winCnt == '0);

  // R6
  cyc_bound_chk: assert property (@(posedge clk) disable iff (!arstN)
    cycCnt < CYC_W'(MAX_CYC));

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl (
  input  logic               clk,
  input  logic               arstN,
  input  logic               porEvt,
  input  logic               lvdEvt,
  input  logic               pinIn,
  input  logic               oscValid,
  input  logic               winTick,
  input  logic               winLast,
  input  logic               driveLast,
  input  logic               waitLast,
  output rstseq_pkg::dpCmd_t dpCmd,
  output logic               intReset,
  output logic               pinDriveEn,
  output logic               selfClkSel,
  output logic               selfClkMode
);
  import rstseq_pkg::*;

  seqState_t state, nxtState;
  logic anyEvt, fallBack;

  assign anyEvt = porEvt | lvdEvt;

  always_comb begin
    nxtState = state;
    fallBack = 1'b0;
    unique case (state)
      ST_QUAL: if (winTick) begin
        if (oscValid) nxtState = ST_DRIVE;
        else if (winLast) begin
          nxtState = ST_DRIVE;
          fallBack = 1'b1;
        end
      end
      ST_DRIVE: if (driveLast) nxtState = ST_WAIT;
      ST_WAIT:  if (waitLast)  nxtState = pinIn ? ST_IDLE : ST_HOLD;
      ST_HOLD:  if (pinIn)     nxtState = ST_IDLE;
      default:  ;
    endcase
    if (anyEvt) begin
      nxtState = ST_QUAL;
      fallBack = 1'b0;
    end
  end

  always_comb begin
    dpCmd.winClr = anyEvt || (state != ST_QUAL);
    dpCmd.winInc = (state == ST_QUAL) && winTick && !oscValid;
    dpCmd.cycClr = anyEvt || (nxtState != state);
    dpCmd.cycInc = (state == ST_DRIVE) || (state == ST_WAIT);
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      state       <= ST_IDLE;
      selfClkSel  <= 1'b0;
      selfClkMode <= 1'b0;
    end else begin
      state <= nxtState;
      if (anyEvt)        selfClkSel <= 1'b0;
      else if (fallBack) selfClkSel <= 1'b1;
      if (porEvt)        selfClkMode <= 1'b0;
      else if (fallBack) selfClkMode <= 1'b1;
    end
  end

  assign intReset   = (state != ST_IDLE);
  assign pinDriveEn = (state == ST_DRIVE);

  // R2
  evt_enters_qual_chk: assert property (@(posedge clk) disable iff (!arstN)
    anyEvt |=> (intReset && !pinDriveEn && state == ST_QUAL));

  // R7
  release_needs_pin_chk: assert property (@(posedge clk) disable iff (!arstN)
    $fell(intReset) |-> $past(pinIn));

  // R8
  sticky_mode_chk: assert property (@(posedge clk) disable iff (!arstN)
    (selfClkMode && !porEvt) |=> selfClkMode);

  // R4
  fallback_origin_chk: assert property (@(posedge clk) disable iff (!arstN)
    $rose(selfClkSel) |-> ($past(state) == ST_QUAL && pinDriveEn));

  // R6
  drive_in_reset_chk: assert property (@(posedge clk) disable iff (!arstN)
    pinDriveEn |-> intReset);

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int NUM_WIN   = 50,
  parameter int DRIVE_CYC = 128,
  parameter int WAIT_CYC  = 64
) (
  input  logic clk,
  input  logic arstN,
  input  logic porEvt,
  input  logic lvdEvt,
  input  logic pinIn,
  input  logic oscValid,
  input  logic winTick,
  output logic intReset,
  output logic pinDriveEn,
  output logic selfClkSel,
  output logic selfClkMode
);
  rstseq_pkg::dpCmd_t dpCmd;
  logic winLast, driveLast, waitLast;

  rstseq_ctrl i_ctrl (
    .clk(clk), .arstN(arstN), .porEvt(porEvt), .lvdEvt(lvdEvt),
    .pinIn(pinIn), .oscValid(oscValid), .winTick(winTick),
    .winLast(winLast), .driveLast(driveLast), .waitLast(waitLast),
    .dpCmd(dpCmd), .intReset(intReset), .pinDriveEn(pinDriveEn),
    .selfClkSel(selfClkSel), .selfClkMode(selfClkMode)
  );

  rstseq_dpath #(
    .NUM_WIN(NUM_WIN), .DRIVE_CYC(DRIVE_CYC), .WAIT_CYC(WAIT_CYC)
  ) i_dpath (
    .clk(clk), .arstN(arstN), .dpCmd(dpCmd),
    .winLast(winLast), .driveLast(driveLast), .waitLast(waitLast)
  );

endmodule

// File: tb/test_rstseq_top.sv
module test_rstseq_top;
  localparam int CLK_PER = 10;
  localparam int NWIN    = 50;
  localparam int NDRIVE  = 128;
  localparam int NWAIT   = 64;

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic porEvt = 1'b0, lvdEvt = 1'b0, oscValid = 1'b0, winTick = 1'b0;
  logic extLow = 1'b0;
  logic pinIn;
  logic intReset, pinDriveEn, selfClkSel, selfClkMode;

  int checks = 0;
  int errors = 0;
  logic expMode = 1'b0;

  assign pinIn = !(pinDriveEn || extLow);

  always #(CLK_PER/2) clk = ~clk;

  rstseq_top i_rstseq_top (
    .clk(clk), .arstN(arstN), .porEvt(porEvt), .lvdEvt(lvdEvt),
    .pinIn(pinIn), .oscValid(oscValid), .winTick(winTick),
    .intReset(intReset), .pinDriveEn(pinDriveEn),
    .selfClkSel(selfClkSel), .selfClkMode(selfClkMode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int winsNeeded(input int nBad);
    return (nBad >= NWIN) ? NWIN : nBad + 1;
  endfunction

  function automatic logic nextMode(input logic prev, input logic isPor, input int nBad);
    return (isPor ? 1'b0 : prev) | (nBad >= NWIN);
  endfunction

  task automatic pulseEvt(input logic isPor);
    porEvt = isPor;
    lvdEvt = !isPor;
    @(negedge clk);
    porEvt = 1'b0;
    lvdEvt = 1'b0;
    chk("R2 intReset after event", intReset, 1);
    chk("R2 no drive during qualification", pinDriveEn, 0);
  endtask

  // windows, drive, wait, optional hold; sampled at negedges
  task automatic finishSeq(input logic isPor, input int nBad, input int gap, input int extra);
    int nWin = winsNeeded(nBad);
    logic earlyDrive = 1'b0;
    int n;
    extLow = (extra > 0);
    for (int w = 0; w < nWin; w++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (pinDriveEn) earlyDrive = 1'b1;
      end
      winTick  = 1'b1;
      oscValid = (w >= nBad);
      @(negedge clk);
      winTick  = 1'b0;
      oscValid = 1'b0;
      if (w < nWin - 1 && pinDriveEn) earlyDrive = 1'b1;
    end
    chk("R4/R5 no drive before last window", earlyDrive, 0);
    chk("R3/R4 drive starts after deciding window", pinDriveEn, 1);
    chk("R3/R4 clock select", selfClkSel, (nBad >= NWIN));
    expMode = nextMode(expMode, isPor, nBad);
    chk("R4/R8 self-clock status", selfClkMode, expMode);
    n = 0;
    while (pinDriveEn && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R6 drive length", n, NDRIVE);
    n = 0;
    while (intReset && n < 2000) begin
      if (n == NWAIT - 1 + extra) extLow = 1'b0;
      n++;
      @(negedge clk);
    end
    extLow = 1'b0;
    chk("R7 reset tail length", n, NWAIT + extra);
  endtask

  initial begin
    repeat (CLK_PER * 150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk("R1 intReset in reset", intReset, 0);
    chk("R1 pinDriveEn in reset", pinDriveEn, 0);
    arstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 intReset idle", intReset, 0);
    chk("R1 selfClkSel idle", selfClkSel, 0);
    chk("R1 selfClkMode idle", selfClkMode, 0);

    // R5 / R10: ticks and low pin while idle
    winTick = 1'b1; oscValid = 1'b1; extLow = 1'b1;
    repeat (3) @(negedge clk);
    winTick = 1'b0; oscValid = 1'b0; extLow = 1'b0;
    chk("R5 R10 idle inputs ignored", intReset, 0);
    chk("R5 idle inputs no drive", pinDriveEn, 0);

    // directed: good clock first window, por
    pulseEvt(1'b1);
    finishSeq(1'b1, 0, 2, 0);
    // directed: exactly 49 bad then good
    pulseEvt(1'b0);
    finishSeq(1'b0, 49, 0, 0);
    // directed: fallback, then pin held low
    pulseEvt(1'b0);
    finishSeq(1'b0, 50, 1, 7);
    // R8: sticky across lvd with good clock
    pulseEvt(1'b0);
    finishSeq(1'b0, 3, 0, 0);
    chk("R8 sticky after lvd", selfClkMode, 1);

    // R9: interrupt during drive
    pulseEvt(1'b0);
    for (int w = 0; w < NWIN; w++) begin
      winTick = 1'b1;
      @(negedge clk);
      winTick = 1'b0;
    end
    repeat (10) @(negedge clk);
    chk("R9 in drive before restart", pinDriveEn, 1);
    chk("R9 self select before restart", selfClkSel, 1);
    pulseEvt(1'b0);
    chk("R9 drive stops on restart", pinDriveEn, 0);
    chk("R9 select back to oscillator", selfClkSel, 0);
    chk("R9 sticky kept on lvd restart", selfClkMode, 1);
    // R9: interrupt during qualification after 30 bad windows
    for (int w = 0; w < 30; w++) begin
      winTick = 1'b1;
      @(negedge clk);
      winTick = 1'b0;
    end
    pulseEvt(1'b1);
    chk("R8 por clears status", selfClkMode, 0);
    finishSeq(1'b1, 50, 0, 0);

    // random sequences
    for (int k = 0; k < 12; k++) begin
      logic isPor = $urandom_range(0, 1) == 1;
      int nBad = $urandom_range(0, 55);
      int gap = $urandom_range(0, 3);
      int extra = $urandom_range(0, 5);
      pulseEvt(isPor);
      finishSeq(isPor, nBad, gap, extra);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule